// File: doc/BRIEF.md
# Quarter-Word Multiply-Accumulate Unit

This block multiplies one quarter-word taken from each of two wide operands. It moves the double-width product up by zero to three quarter-word positions and adds it into an internal accumulator that is as wide as the operands. Chains of these operations build full-width products from partial products, so a software sequence can form a wide multiplication without a wide multiplier.

Each operation can also produce a write to a destination register. In shift-out mode the low half of the new accumulator goes to one chosen half of the destination, and the accumulator then drops that half by shifting right. In write-out mode the whole new accumulator is written. In the third mode only the accumulator changes. The register file sits outside the block. It receives the write data, a write enable and a two-bit mask that says which halves of the destination to update.

Top module: `qw_mac_unit`

## Requirements
- R1: After reset, wr_en_o is 0, wr_mask_o is 2'b00, wr_data_o is 0 and the accumulator holds 0.
- R2: Selector value k on sel_a_i or sel_b_i picks operand bits [k*WIDTH/4 + WIDTH/4 - 1 : k*WIDTH/4]. The value 0 picks the least significant quarter and 3 picks the most significant.
- R3: The two selected quarter-words are multiplied as unsigned numbers into a WIDTH/2-bit product.
- R4: The product is shifted left by prod_shift_i*WIDTH/4 bits and added to the accumulator modulo 2^WIDTH. Bits above WIDTH-1 are dropped, both from the shift and from the carry out of the sum.
- R5: When clear_acc_i is 1, the shifted product is added to zero instead of to the old accumulator.
- R6: With wb_mode_i equal to 0 (none) or 3 (reserved, treated as none), the accumulator updates and the next cycle shows wr_en_o=0, wr_mask_o=2'b00 and wr_data_o=0.
- R7: With wb_mode_i=1 (shift-out), wr_en_o is 1 and the low half of the new accumulator is written to one half of the destination, chosen by half_sel_i. If half_sel_i=0 it goes to wr_data_o[WIDTH/2-1:0] with mask 2'b01. If half_sel_i=1 it goes to wr_data_o[WIDTH-1:WIDTH/2] with mask 2'b10. The unselected half of wr_data_o is 0.
- R8: After a shift-out operation, the accumulator holds the new accumulator value shifted right by WIDTH/2.
- R9: With wb_mode_i=2 (write-out), wr_en_o is 1, wr_mask_o is 2'b11 and wr_data_o is the whole new accumulator.
- R10: Results appear one clock after the operation is presented with op_valid_i=1. While op_valid_i=0, the next cycle shows no write and the accumulator keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation present this cycle |
| src_a_i | input | WIDTH | First wide operand |
| src_b_i | input | WIDTH | Second wide operand |
| sel_a_i | input | 2 | Quarter-word select for src_a_i |
| sel_b_i | input | 2 | Quarter-word select for src_b_i |
| prod_shift_i | input | 2 | Product offset in quarter-words |
| clear_acc_i | input | 1 | Add into zero instead of the accumulator |
| wb_mode_i | input | 2 | 0 none, 1 shift-out, 2 write-out, 3 none |
| half_sel_i | input | 1 | Shift-out target half: 0 lower, 1 upper |
| wr_data_o | output | WIDTH | Destination write data |
| wr_en_o | output | 1 | Destination write enable |
| wr_mask_o | output | 2 | Half-word enables: bit 0 lower, bit 1 upper |

## Verification
Every write result is due at the first rising edge after the operation is applied, and it stays until the next edge. The bench therefore drives each operation on a falling edge and samples the write outputs on the following falling edge. The accumulator is not visible at the ports. Its state after a none-mode operation, an idle cycle or a shift-out is shown one operation later, by a write-out whose product is zero, and that write is itself sampled one cycle after it is applied. The sweeps run on a 16-bit configuration, so every selector and shift combination can be compared against products and sums computed arithmetically in the bench.

// File: rtl/qw_mac_pkg.sv
package qw_mac_pkg;

    localparam int unsigned QUARTERS = 4;

    typedef enum logic [1:0] {
        WB_NONE      = 2'd0,
        WB_SHIFT_OUT = 2'd1,
        WB_WRITE_OUT = 2'd2,
        WB_RESERVED  = 2'd3
    } wb_mode_e;

endpackage

// File: rtl/qw_mac_select.sv
module qw_mac_select #(
    parameter int unsigned WIDTH = 256
) (
    input  logic [WIDTH-1:0]           word_i,
    input  logic [1:0]                 sel_i,
    output logic [WIDTH/4-1:0]         qw_o
);
    localparam int unsigned QW = WIDTH / qw_mac_pkg::QUARTERS;

    logic [QW-1:0] parts [qw_mac_pkg::QUARTERS];

    for (genvar k = 0; k < qw_mac_pkg::QUARTERS; k++) begin : g_part
        assign parts[k] = word_i[k*QW +: QW];
    end

    assign qw_o = parts[sel_i];
endmodule

// File: rtl/qw_mac_mul.sv
module qw_mac_mul #(
    parameter int unsigned QW = 64
) (
    input  logic [QW-1:0]   a_i,
    input  logic [QW-1:0]   b_i,
    output logic [2*QW-1:0] prod_o
);
    localparam int unsigned PW = 2 * QW;

    assign prod_o = PW'(a_i) * PW'(b_i);
endmodule

// File: rtl/qw_mac_align.sv
module qw_mac_align #(
    parameter int unsigned WIDTH = 256
) (
    input  logic [WIDTH/2-1:0] prod_i,
    input  logic [1:0]         shift_i,
    output logic [WIDTH-1:0]   aligned_o
);
    localparam int unsigned QW   = WIDTH / qw_mac_pkg::QUARTERS;
    localparam int unsigned HALF = WIDTH / 2;

    logic [WIDTH-1:0] ext;
    logic [WIDTH-1:0] cand [qw_mac_pkg::QUARTERS];

    assign ext = {{HALF{1'b0}}, prod_i};

    for (genvar k = 0; k < qw_mac_pkg::QUARTERS; k++) begin : g_pos
        assign cand[k] = ext << (k * QW);
    end

    assign aligned_o = cand[shift_i];
endmodule

// File: rtl/qw_mac_unit.sv
module qw_mac_unit
    import qw_mac_pkg::*;
#(
    parameter int unsigned WIDTH = 256
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             op_valid_i,
    input  logic [WIDTH-1:0] src_a_i,
    input  logic [WIDTH-1:0] src_b_i,
    input  logic [1:0]       sel_a_i,
    input  logic [1:0]       sel_b_i,
    input  logic [1:0]       prod_shift_i,
    input  logic             clear_acc_i,
    input  logic [1:0]       wb_mode_i,
    input  logic             half_sel_i,
    output logic [WIDTH-1:0] wr_data_o,
    output logic             wr_en_o,
    output logic [1:0]       wr_mask_o
);
    localparam int unsigned QW   = WIDTH / QUARTERS;
    localparam int unsigned HALF = WIDTH / 2;

    typedef struct packed {
        logic [WIDTH-1:0] acc;
        logic [WIDTH-1:0] data;
        logic             wen;
        logic [1:0]       mask;
    } mac_state_t;

    mac_state_t st_d, st_q;

    logic [QW-1:0]    qw_a, qw_b;
    logic [HALF-1:0]  product;
    logic [WIDTH-1:0] aligned;
    logic [WIDTH-1:0] acc_base;
    logic [WIDTH-1:0] acc_sum;

    qw_mac_select #(.WIDTH(WIDTH)) u_sel_a (
        .word_i (src_a_i),
        .sel_i  (sel_a_i),
        .qw_o   (qw_a)
    );

    qw_mac_select #(.WIDTH(WIDTH)) u_sel_b (
        .word_i (src_b_i),
        .sel_i  (sel_b_i),
        .qw_o   (qw_b)
    );

    qw_mac_mul #(.QW(QW)) u_mul (
        .a_i    (qw_a),
        .b_i    (qw_b),
        .prod_o (product)
    );

    qw_mac_align #(.WIDTH(WIDTH)) u_align (
        .prod_i    (product),
        .shift_i   (prod_shift_i),
        .aligned_o (aligned)
    );

    always_comb begin
        acc_base = clear_acc_i ? '0 : st_q.acc;
        acc_sum  = acc_base + aligned;

        st_d      = st_q;
        st_d.wen  = 1'b0;
        st_d.mask = 2'b00;
        st_d.data = '0;

        if (op_valid_i) begin
            st_d.acc = acc_sum;
            case (wb_mode_i)
                WB_SHIFT_OUT: begin
                    st_d.wen = 1'b1;
                    if (half_sel_i) begin
                        st_d.mask = 2'b10;
                        st_d.data = {acc_sum[HALF-1:0], {HALF{1'b0}}};
                    end else begin
                        st_d.mask = 2'b01;
                        st_d.data = {{HALF{1'b0}}, acc_sum[HALF-1:0]};
                    end
                    st_d.acc = acc_sum >> HALF;
                end
                WB_WRITE_OUT: begin
                    st_d.wen  = 1'b1;
                    st_d.mask = 2'b11;
                    st_d.data = acc_sum;
                end
                default: begin
                    st_d.wen = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_data_o = st_q.data;
    assign wr_en_o   = st_q.wen;
    assign wr_mask_o = st_q.mask;

    // R10: an idle cycle produces no write
    a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !op_valid_i |=> (!wr_en_o && wr_mask_o == 2'b00));

    // R10: an idle cycle leaves the accumulator untouched
    a_r10_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !op_valid_i |=> $stable(st_q.acc));

    // R6: none and reserved modes never write
    a_r6_none_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && (wb_mode_i == WB_NONE || wb_mode_i == WB_RESERVED))
        |=> !wr_en_o);

    // R9: write-out enables both halves
    a_r9_full_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && wb_mode_i == WB_WRITE_OUT)
        |=> (wr_en_o && wr_mask_o == 2'b11));

    // R7: shift-out enables exactly the chosen half
    a_r7_half_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && wb_mode_i == WB_SHIFT_OUT)
        |=> (wr_en_o && wr_mask_o == ($past(half_sel_i) ? 2'b10 : 2'b01)));

    // R8: after shift-out the upper half of the accumulator is empty
    a_r8_upper_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && wb_mode_i == WB_SHIFT_OUT)
        |=> (st_q.acc[WIDTH-1:HALF] == '0));

    // R7: an enabled write always names at least one half
    a_r7_mask_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> ($countones(wr_mask_o) >= 1));
endmodule

// File: tb/qw_mac_unit_bench.sv
module qw_mac_unit_bench;
    localparam int unsigned W = 16;
    localparam int unsigned Q = W / 4;
    localparam int unsigned H = W / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [W-1:0] src_a = '0;
    logic [W-1:0] src_b = '0;
    logic [1:0]   sel_a = '0;
    logic [1:0]   sel_b = '0;
    logic [1:0]   pshift = '0;
    logic         clr = 1'b0;
    logic [1:0]   mode = '0;
    logic         hsel = 1'b0;
    logic [W-1:0] wr_data;
    logic         wr_en;
    logic [1:0]   wr_mask;

    int unsigned  n_total = 0;
    int unsigned  n_bad = 0;
    int unsigned  cyc = 0;
    bit           finished = 1'b0;
    logic [31:0]  seed = 32'h1234_5678;
    logic [W-1:0] m_acc = '0;

    always #4 clk = ~clk;

    qw_mac_unit #(.WIDTH(W)) u_qw_mac_unit (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .op_valid_i   (op_valid),
        .src_a_i      (src_a),
        .src_b_i      (src_b),
        .sel_a_i      (sel_a),
        .sel_b_i      (sel_b),
        .prod_shift_i (pshift),
        .clear_acc_i  (clr),
        .wb_mode_i    (mode),
        .half_sel_i   (hsel),
        .wr_data_o    (wr_data),
        .wr_en_o      (wr_en),
        .wr_mask_o    (wr_mask)
    );

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply one operation at a falling edge, sample at the next falling edge.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [1:0] sa, input logic [1:0] sb,
                          input logic [1:0] sh, input logic c,
                          input logic [1:0] md, input logic hs,
                          input string tag);
        logic [Q-1:0] qa, qb;
        logic [H-1:0] prod;
        logic [W-1:0] placed, sum, e_data, n_acc;
        logic         e_en;
        logic [1:0]   e_mask;
        qa     = a[sa*Q +: Q];
        qb     = b[sb*Q +: Q];
        prod   = H'(qa) * H'(qb);
        placed = W'(prod) << (sh * Q);
        sum    = (c ? '0 : m_acc) + placed;
        n_acc  = sum;
        e_en   = 1'b0;
        e_mask = 2'b00;
        e_data = '0;
        if (md == 2'd1) begin
            e_en   = 1'b1;
            e_mask = hs ? 2'b10 : 2'b01;
            e_data = hs ? {sum[H-1:0], {H{1'b0}}} : {{H{1'b0}}, sum[H-1:0]};
            n_acc  = sum >> H;
        end else if (md == 2'd2) begin
            e_en   = 1'b1;
            e_mask = 2'b11;
            e_data = sum;
        end
        src_a = a; src_b = b; sel_a = sa; sel_b = sb; pshift = sh;
        clr = c; mode = md; hsel = hs; op_valid = 1'b1;
        @(negedge clk);
        chk(32'(wr_en), 32'(e_en), {tag, " wr_en"});
        chk(32'(wr_mask), 32'(e_mask), {tag, " wr_mask"});
        chk(32'(wr_data), 32'(e_data), {tag, " wr_data"});
        m_acc = n_acc;
        op_valid = 1'b0;
    endtask

    // Write-out with zero product: reveals the accumulator unchanged.
    task automatic reveal(input string tag);
        run_op('0, '0, 2'd0, 2'd0, 2'd0, 1'b0, 2'd2, 1'b0, tag);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000 && !finished) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of the outputs
        chk(32'(wr_en), 32'd0, "R1 reset wr_en");
        chk(32'(wr_mask), 32'd0, "R1 reset wr_mask");
        chk(32'(wr_data), 32'd0, "R1 reset wr_data");
        // R1: accumulator starts at zero (no clear, product alone appears)
        run_op(16'h0003, 16'h0005, 2'd0, 2'd0, 2'd0, 1'b0, 2'd2, 1'b0, "R1 acc zero");

        // R2 R3 R4 R5: all selector and shift combinations, cleared each time
        for (int sa = 0; sa < 4; sa++)
            for (int sb = 0; sb < 4; sb++)
                for (int sh = 0; sh < 4; sh++)
                    for (int r = 0; r < 4; r++)
                        run_op(W'(rnd()), W'(rnd()), 2'(sa), 2'(sb), 2'(sh),
                               1'b1, 2'd2, 1'b0, "R2 R3 R4 R5 sweep");

        // R4: carry out of the top bit is dropped
        run_op(16'hFFFF, 16'hFFFF, 2'd1, 2'd2, 2'd2, 1'b1, 2'd2, 1'b0, "R4 wrap first");
        run_op(16'hFFFF, 16'hFFFF, 2'd3, 2'd0, 2'd2, 1'b0, 2'd2, 1'b0, "R4 wrap sum");
        run_op(16'hF000, 16'hF000, 2'd3, 2'd3, 2'd3, 1'b1, 2'd2, 1'b0, "R4 shift drop");

        // R6: none and reserved modes, then reveal
        run_op(16'h00A0, 16'h0700, 2'd1, 2'd2, 2'd1, 1'b1, 2'd0, 1'b0, "R6 none");
        reveal("R6 acc after none");
        run_op(16'h0B00, 16'h000C, 2'd2, 2'd0, 2'd0, 1'b0, 2'd3, 1'b1, "R6 reserved");
        reveal("R6 acc after reserved");

        // R7 R8: shift-out to each half
        run_op(16'h00FF, 16'h00FF, 2'd1, 2'd1, 2'd2, 1'b1, 2'd1, 1'b0, "R7 shift-out low");
        reveal("R8 acc after shift-out low");
        run_op(16'hF0F0, 16'h0E0E, 2'd3, 2'd2, 2'd1, 1'b1, 2'd1, 1'b1, "R7 shift-out high");
        reveal("R8 acc after shift-out high");

        // R10: idle cycle produces no write and keeps the accumulator
        run_op(16'h1234, 16'h5678, 2'd2, 2'd1, 2'd1, 1'b1, 2'd2, 1'b0, "R10 setup");
        src_a = 16'hFFFF; src_b = 16'hFFFF; clr = 1'b1; mode = 2'd2;
        @(negedge clk);
        chk(32'(wr_en), 32'd0, "R10 idle wr_en");
        chk(32'(wr_mask), 32'd0, "R10 idle wr_mask");
        reveal("R10 acc held");

        // R6 R7 R8 R9: long mixed sequence with accumulation
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r;
            r = rnd();
            run_op(W'(rnd()), W'(rnd()), r[1:0], r[3:2], r[5:4],
                   (r[9:7] == 3'd0), r[11:10], r[12], "R6 R7 R8 R9 mixed");
        end
        reveal("R8 R9 final acc");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule